// File: doc/BRIEF.md
# Sub-Second Alarm Comparator with Programmable Compare Width

This block keeps a programmable sub-second alarm value and checks it against a 32-bit synchronous sub-second down-counter that it also holds. Each counting tick lowers the counter by one. On the tick where the counter takes a value whose low-order bits equal those of the alarm, the block emits a one-cycle match pulse. A 6-bit compare count sets how many low-order bits take part in the check. A count of zero turns the sub-second check off, and the pulse then follows the seconds-increment strobe.

In pure binary mode an optional clear-on-alarm setting makes the counter run from all ones down to the alarm value. When it gets there it reloads all ones at that same clock edge. In BCD mode the clear-on-alarm setting has no effect, and only counter bits [14:0] are ever compared.

The alarm registers are loaded through a valid/ready write port. `wr_ready` is high only while the alarm is disabled or init mode is active. A beat is taken when `wr_valid` and `wr_ready` are both high. A beat offered while `wr_ready` is low is dropped, not stalled, so a writer that holds `wr_valid` simply waits. Two views write the same alarm storage: a 32-bit binary view and a control view that carries the low 15 alarm bits together with the compare count and the clear-on-alarm bit.

Top module: `subsec_alarm`

## Requirements
- R1: After reset, the counter reads 0, `match` is low, and the alarm value, compare count and clear-on-alarm bit are all 0.
- R2: Each cycle with `tick` high lowers `cnt_value` by one, and 0 wraps to 0xFFFFFFFF. With `tick` low the counter holds its value.
- R3: In binary mode (`bin_mode`=1) with compare count N from 1 to 31, a match compares only counter bits [N-1:0] with the alarm.
- R4: With a compare count from 32 to 63 in binary mode, all 32 bits must be equal for a match.
- R5: With compare count 0, ticks never match. A `sec_inc` pulse produces a match, and the counter is left unchanged.
- R6: In BCD mode (`bin_mode`=0), counter bits [31:15] are never compared, whatever the compare count.
- R7: In binary mode with clear-on-alarm set, the tick that would bring the counter to the full 32-bit alarm value instead loads 0xFFFFFFFF at that same edge, and `match` pulses if the masked compare holds.
- R8: In BCD mode the clear-on-alarm bit is ignored and the counter keeps counting down freely.
- R9: `wr_ready` = !`alarm_en` || `init_mode`. A write beat offered while `wr_ready` is low leaves all alarm state unchanged.
- R10: `wr_sel`=1 (binary view) writes all 32 alarm bits from `wr_data`. `wr_sel`=0 (control view) writes alarm bits [14:0] from `wr_data[14:0]`, the compare count from `wr_data[21:16]` and clear-on-alarm from `wr_data[24]`, and keeps alarm bits [31:15].
- R11: `match` is registered at the edge that takes the tick or `sec_inc`. It is high for one cycle per matching event, only while `alarm_en` was high, and `cnt_value` in that cycle shows the counter value reached at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter decrement strobe |
| sec_inc | input | 1 | Seconds-units increment strobe |
| bin_mode | input | 1 | 1 = pure binary, 0 = BCD |
| alarm_en | input | 1 | Alarm enable |
| init_mode | input | 1 | Init mode flag, opens writes |
| wr_valid | input | 1 | Write beat offered |
| wr_ready | output | 1 | Write beat will be accepted |
| wr_sel | input | 1 | 1 = binary view, 0 = control view |
| wr_data | input | 32 | Write data |
| cnt_value | output | 32 | Sub-second counter |
| match | output | 1 | Alarm match pulse |

## Verification
The bench steers the counter across the low-bit compare pattern, where a design with the mask off by one would pulse at twice or half the expected rate. It also steers the counter across a full 32-bit value, where a design that dropped the upper bits would pulse again and again. In BCD mode it uses an alarm whose upper bits are garbage, so a design that compared bits above 14 would never pulse. It also covers the clear-on-alarm reload and its suppression in BCD mode, where a wrong design would either fail to jump to all ones or jump when it should not. Finally it offers write beats while writes are blocked, so a design that accepted them would pulse at the rejected value, and it checks that a control-view write keeps the upper alarm bits.

// File: rtl/subsec_alarm_pkg.sv
`timescale 1ns/1ps
package subsec_alarm_pkg;
  typedef enum logic {
    VIEW_CTRL = 1'b0,
    VIEW_BIN  = 1'b1
  } wr_view_e;

  localparam int unsigned CTRL_LOW_LSB = 0;
  localparam int unsigned CTRL_CNT_LSB = 16;
  localparam int unsigned CTRL_CLR_BIT = 24;
endpackage

// File: rtl/subsec_alarm_regs.sv
`timescale 1ns/1ps
module subsec_alarm_regs
  import subsec_alarm_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int SUB_W  = 15,
  parameter int NCNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm_en,
  input  logic              init_mode,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [CNT_W-1:0]  alm_q,
  output logic [NCNT_W-1:0] ncnt_q,
  output logic              clr_q
);
  logic take;

  assign wr_ready = !alarm_en || init_mode;
  assign take     = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alm_q  <= '0;
      ncnt_q <= '0;
      clr_q  <= 1'b0;
    end else if (take) begin
      if (wr_view_e'(wr_sel) == VIEW_BIN) begin
        alm_q <= wr_data;
      end else begin
        alm_q[SUB_W-1:0] <= wr_data[CTRL_LOW_LSB +: SUB_W];
        ncnt_q           <= wr_data[CTRL_CNT_LSB +: NCNT_W];
        clr_q            <= wr_data[CTRL_CLR_BIT];
      end
    end
  end

  AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && !init_mode) |=> ($stable(alm_q) && $stable(ncnt_q) && $stable(clr_q))); // R9
endmodule

// File: rtl/subsec_cmp_mask.sv
`timescale 1ns/1ps
module subsec_cmp_mask #(
  parameter int CNT_W  = 32,
  parameter int SUB_W  = 15,
  parameter int NCNT_W = 6
) (
  input  logic [NCNT_W-1:0] ncnt,
  input  logic              bin_mode,
  output logic [CNT_W-1:0]  keep
);
  for (genvar i = 0; i < CNT_W; i++) begin : g_bit
    localparam int unsigned IDX = i;
    logic in_range;
    assign in_range = 32'(ncnt) > IDX;
    if (i < SUB_W) begin : g_low
      assign keep[i] = in_range;
    end else begin : g_high
      assign keep[i] = in_range && bin_mode;
    end
  end
endmodule

// File: rtl/subsec_down_counter.sv
`timescale 1ns/1ps
module subsec_down_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             reload_en,
  input  logic [CNT_W-1:0] reload_at,
  output logic [CNT_W-1:0] dec_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  assign dec_o = cnt_q - CNT_W'(1);
  assign nxt_o = (reload_en && (dec_o == reload_at)) ? ALL_ONES : dec_o;

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= nxt_o;
  end

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/subsec_alarm.sv
`timescale 1ns/1ps
module subsec_alarm #(
  parameter int CNT_W  = 32,
  parameter int SUB_W  = 15,
  parameter int NCNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sec_inc,
  input  logic             bin_mode,
  input  logic             alarm_en,
  input  logic             init_mode,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_value,
  output logic             match
);
  logic [CNT_W-1:0]  alm;
  logic [NCNT_W-1:0] ncnt;
  logic              clr;
  logic [CNT_W-1:0]  keep;
  logic [CNT_W-1:0]  dec;
  logic [CNT_W-1:0]  nxt;
  logic              no_cmp;
  logic              hit;

  subsec_alarm_regs #(.CNT_W(CNT_W), .SUB_W(SUB_W), .NCNT_W(NCNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en), .init_mode(init_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_sel(wr_sel), .wr_data(wr_data),
    .alm_q(alm), .ncnt_q(ncnt), .clr_q(clr)
  );

  subsec_cmp_mask #(.CNT_W(CNT_W), .SUB_W(SUB_W), .NCNT_W(NCNT_W)) u_mask (
    .ncnt(ncnt), .bin_mode(bin_mode), .keep(keep)
  );

  subsec_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(tick), .reload_en(clr && bin_mode),
    .reload_at(alm), .dec_o(dec), .nxt_o(nxt), .cnt_q(cnt_value)
  );

  assign no_cmp = (ncnt == '0);
  assign hit    = alarm_en && (no_cmp ? sec_inc
                                      : (tick && (((dec ^ alm) & keep) == '0)));

  always_ff @(posedge clk) begin
    if (!rst_n) match <= 1'b0;
    else        match <= hit;
  end

  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> $past(alarm_en)); // R11
  AST_ZERO_CNT_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(no_cmp)) |-> $past(sec_inc)); // R5
  AST_BCD_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !bin_mode) |=> (cnt_value == $past(cnt_value) - CNT_W'(1))); // R8
endmodule

// File: tb/sim_subsec_alarm.sv
`timescale 1ns/1ps
module sim_subsec_alarm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sec_inc = 1'b0, bin_mode = 1'b1, alarm_en = 1'b0, init_mode = 1'b0;
  logic wr_valid = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_ready, match;
  logic [31:0] cnt_value;

  always #10 clk = ~clk;

  subsec_alarm u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sec_inc(sec_inc), .bin_mode(bin_mode),
    .alarm_en(alarm_en), .init_mode(init_mode), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_data(wr_data), .cnt_value(cnt_value), .match(match)
  );

  int checks = 0, errors = 0, seen = 0;
  logic [31:0] exp_q[$];
  logic [31:0] m_cnt = '0, m_alm = '0;
  logic [5:0]  m_n = '0;
  logic        m_clr = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pop scoreboard on each match pulse
  always @(negedge clk) begin
    if (rst_n && match) begin
      seen++;
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected match", cnt_value, 32'hx);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(cnt_value == e, "R11 match count value", cnt_value, e);
      end
    end
  end

  function automatic bit m_hit(input logic [31:0] v);
    bit ok = 1'b1;
    if (!alarm_en || m_n == 0) return 1'b0;
    for (int i = 0; i < 32; i++)
      if ((m_n > i) && (bin_mode || i < 15) && (v[i] != m_alm[i])) ok = 1'b0;
    return ok;
  endfunction

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      logic [31:0] d, nx;
      d  = m_cnt - 32'd1;
      nx = (bin_mode && m_clr && d == m_alm) ? 32'hFFFF_FFFF : d;
      if (m_hit(d)) exp_q.push_back(nx);
      m_cnt = nx;
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic sec_pulse();
    if (alarm_en && m_n == 0) exp_q.push_back(m_cnt);
    sec_inc = 1'b1;
    @(negedge clk);
    sec_inc = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    bit rdy;
    rdy = !alarm_en || init_mode;
    wr_valid = 1'b1; wr_sel = sel; wr_data = d;
    #1 chk(wr_ready == rdy, "R9 wr_ready", {31'd0, wr_ready}, {31'd0, rdy});
    if (rdy) begin
      if (sel) m_alm = d;
      else begin
        m_alm[14:0] = d[14:0];
        m_n = d[21:16];
        m_clr = d[24];
      end
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic settle(input string req, input int exp_n);
    @(negedge clk); @(negedge clk);
    chk(exp_q.size() == 0, {req, " missed match"}, exp_q.size(), 0);
    chk(seen == exp_n, {req, " match count"}, seen, exp_n);
    chk(cnt_value == m_cnt, {req, " counter"}, cnt_value, m_cnt);
    seen = 0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt_value == 32'd0, "R1 counter after reset", cnt_value, 0);
    chk(match == 1'b0, "R1 match after reset", {31'd0, match}, 0);
    chk(wr_ready == 1'b1, "R1 ready after reset", {31'd0, wr_ready}, 1);
    // R2 wrap from zero
    ticks(1);
    chk(cnt_value == 32'hFFFF_FFFF, "R2 wrap", cnt_value, 32'hFFFF_FFFF);
    settle("R2", 0);
    // R3 low-bit compare, N=3
    wr(1'b1, 32'hFFFF_FFF8);
    wr(1'b0, (32'd3 << 16) | 32'h7FF8);
    alarm_en = 1'b1;
    ticks(20);
    settle("R3", 2);
    // R4 full compare, N=40
    alarm_en = 1'b0;
    wr(1'b1, 32'hFFFF_FFE0);
    wr(1'b0, (32'd40 << 16) | 32'h7FE0);
    alarm_en = 1'b1;
    ticks(16);
    settle("R4", 1);
    // R6 BCD ignores high bits
    alarm_en = 1'b0; bin_mode = 1'b0;
    wr(1'b1, 32'h1234_7FD0);
    alarm_en = 1'b1;
    ticks(16);
    settle("R6", 1);
    // R10 control view keeps upper alarm bits
    alarm_en = 1'b0; bin_mode = 1'b1;
    wr(1'b1, 32'hFFFF_FFFF);
    wr(1'b0, (32'd40 << 16) | 32'h7FC0);
    alarm_en = 1'b1;
    ticks(16);
    settle("R10", 1);
    // R9 blocked write then init-mode write
    wr(1'b1, 32'hFFFF_FFB5);
    ticks(16);
    settle("R9 blocked", 0);
    init_mode = 1'b1;
    wr(1'b1, 32'hFFFF_FFA5);
    init_mode = 1'b0;
    ticks(16);
    settle("R9 init", 1);
    // R5 zero compare count
    alarm_en = 1'b0;
    wr(1'b0, 32'h0000_7F90);
    alarm_en = 1'b1;
    sec_pulse();
    ticks(4);
    alarm_en = 1'b0;
    sec_pulse();
    settle("R5", 1);
    // R7 clear-on-alarm reload in binary mode
    wr(1'b0, (32'd1 << 24) | (32'd40 << 16) | 32'h7F90);
    alarm_en = 1'b1;
    ticks(120);
    settle("R7", 2);
    // R8 clear-on-alarm ignored in BCD mode
    bin_mode = 1'b0;
    ticks(130);
    settle("R8", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule